// File: doc/BRIEF.md
# Interrupt Level State Stacker

This block keeps a processor's live status word and the context saved for each nested interrupt level. On an interrupt entry it saves the live status, the program counter, the exception address and the entry type. When the core is already inside a handler, the earlier saved copies move one slot deeper into a "previous" shadow slot, and two live general registers are captured next to them. A return pops the chain back up. The current nesting level is held in a two-bit field of the live status word, and it stops at a configurable maximum of 2 or 3. An entry taken at the maximum level stores its return PC in a separate overflow slot and leaves the chain as it is.

A debugger reads any saved register through a select input. The read path is combinational. The debugger writes a register with a write strobe, and the write lands on the next clock edge. Every pin is a plain control or status pin, so there is no handshake and no back-pressure. An event strobe is sampled on each rising edge while it is high.

Top module: `ils_stacker`

## Requirements
- R1: After reset the live status, every saved and previous slot, the overflow PC and all outputs read zero.
- R2: The nesting level is status bits [2:1]. It never exceeds MAX_LEVEL (2 or 3).
- R3: An entry (`irq_i`) below MAX_LEVEL does four things on the next edge. It copies the live status into the saved status (select 1). It copies `pc_i` into the saved PC (select 3), `irq_addr_i` into the exception address (select 6) and `irq_type_i` into the type register (select 8). In the live status it raises the level by one and clears bit 0 (interrupt enable), bit 6 (instruction translation), bit 7 (data translation) and bit 11 (single-step).
- R4: An entry taken at level 1 or above first moves the saved status, PC, exception address and type into their previous slots (selects 2, 4, 7, 9). It also captures `gpr26_i` and `gpr27_i` into selects 10 and 11.
- R5: An entry taken at MAX_LEVEL writes `pc_i` into the overflow PC (select 5) and changes no other register.
- R6: A return (`ret_i`) at level above 0 does two things. It moves each previous slot back into its saved slot. It loads the live status from the saved status, with the level field forced to the old level minus one.
- R7: A return at level 0 changes nothing.
- R8: `dbg_reason_o` is the low 4 bits of the type register.
- R9: With `dbg_we_i` high, `dbg_wdata_i` is written to the register chosen by `dbg_sel_i` on the next edge (select 0 is the live status). `dbg_rdata_o` shows the selected register, and it reads 0 for selects 12 to 15.
- R10: An entry or return in the same cycle as a debugger write wins, and the write is dropped. An entry also wins over a return in the same cycle.
- R11: The single-step bit moves down the chain with the status word, so it can end up set in the previous saved status.
- R12: `ret_pc_o` always equals the saved PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | Interrupt entry strobe |
| irq_type_i | input | 4 | Entry type code |
| irq_addr_i | input | 32 | Exception address |
| pc_i | input | 32 | Live program counter |
| gpr26_i | input | 32 | Live general register 26 |
| gpr27_i | input | 32 | Live general register 27 |
| ret_i | input | 1 | Return-from-interrupt strobe |
| dbg_we_i | input | 1 | Debugger write strobe |
| dbg_sel_i | input | 4 | Debugger register select |
| dbg_wdata_i | input | 32 | Debugger write data |
| dbg_rdata_o | output | 32 | Selected register value |
| status_o | output | 32 | Live status word |
| ret_pc_o | output | 32 | Return PC (saved PC) |
| dbg_reason_o | output | 4 | Debug reason (type low bits) |

## Verification
The bench goes after the depth boundaries first. A design that pushes the chain on an entry at the maximum level would corrupt the saved status instead of filling the overflow slot. A design that pops at level 0 would make the level wrap to 3. Nested entries check that the single-step bit from a level-1 status reaches the previous slot; a chain that shifted the wrong copy, or cleared the bit before saving it, shows the wrong value there. Collisions check that an event overrides a debugger write and that an entry beats a return. A design that merged a collision would leave the debugger's value in the status word.

// File: rtl/ils_pkg.sv
package ils_pkg;
  localparam int DW = 32;
  localparam int SELW = 4;
  localparam int NCHAIN = 4;
  // bit positions inside the status word
  localparam int B_GIE = 0;
  localparam int B_LVL_LO = 1;
  localparam int B_IT = 6;
  localparam int B_DT = 7;
  localparam int B_SS = 11;
  // debugger selects
  localparam logic [SELW-1:0] S_STAT  = 4'd0;
  localparam logic [SELW-1:0] S_SST   = 4'd1;
  localparam logic [SELW-1:0] S_PSST  = 4'd2;
  localparam logic [SELW-1:0] S_SPC   = 4'd3;
  localparam logic [SELW-1:0] S_PSPC  = 4'd4;
  localparam logic [SELW-1:0] S_OVPC  = 4'd5;
  localparam logic [SELW-1:0] S_EVA   = 4'd6;
  localparam logic [SELW-1:0] S_PEVA  = 4'd7;
  localparam logic [SELW-1:0] S_TYP   = 4'd8;
  localparam logic [SELW-1:0] S_PTYP  = 4'd9;
  localparam logic [SELW-1:0] S_PG26  = 4'd10;
  localparam logic [SELW-1:0] S_PG27  = 4'd11;

  function automatic logic [DW-1:0] set_level(input logic [DW-1:0] w, input logic [1:0] l);
    logic [DW-1:0] r;
    r = w;
    r[B_LVL_LO +: 2] = l;
    return r;
  endfunction
endpackage

// File: rtl/ils_shadow.sv
module ils_shadow #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         deep,
  input  logic         pop,
  input  logic [W-1:0] din,
  input  logic         wr_top,
  input  logic         wr_prev,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top  <= '0;
      prev <= '0;
    end else if (push) begin
      top <= din;
      if (deep) prev <= top;
    end else if (pop) begin
      top <= prev;
    end else begin
      if (wr_top)  top  <= wdata;
      if (wr_prev) prev <= wdata;
    end
  end
endmodule

// File: rtl/ils_ctrl.sv
module ils_ctrl
  import ils_pkg::*;
#(
  parameter int MAX_LEVEL = 3
) (
  input  logic          irq,
  input  logic          ret,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] sst,
  output logic          push,
  output logic          deep,
  output logic          pop,
  output logic          ovf,
  output logic          dbg_ok,
  output logic [DW-1:0] status_nxt
);
  localparam logic [1:0] MAXL = 2'(MAX_LEVEL);
  logic [1:0] lvl;
  logic [DW-1:0] cleared;

  always_comb begin
    lvl  = status[B_LVL_LO +: 2];
    push = irq && (lvl < MAXL);
    ovf  = irq && (lvl >= MAXL);
    deep = lvl != 2'd0;
    pop  = !irq && ret && (lvl != 2'd0);
    dbg_ok = !irq && !ret;
    cleared = status;
    cleared[B_GIE] = 1'b0;
    cleared[B_IT]  = 1'b0;
    cleared[B_DT]  = 1'b0;
    cleared[B_SS]  = 1'b0;
    if (push)     status_nxt = set_level(cleared, lvl + 2'd1);
    else if (pop) status_nxt = set_level(sst, lvl - 2'd1);
    else          status_nxt = status;
  end
endmodule

// File: rtl/ils_stacker.sv
module ils_stacker
  import ils_pkg::*;
#(
  parameter int MAX_LEVEL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_i,
  input  logic [3:0]      irq_type_i,
  input  logic [DW-1:0]   irq_addr_i,
  input  logic [DW-1:0]   pc_i,
  input  logic [DW-1:0]   gpr26_i,
  input  logic [DW-1:0]   gpr27_i,
  input  logic            ret_i,
  input  logic            dbg_we_i,
  input  logic [SELW-1:0] dbg_sel_i,
  input  logic [DW-1:0]   dbg_wdata_i,
  output logic [DW-1:0]   dbg_rdata_o,
  output logic [DW-1:0]   status_o,
  output logic [DW-1:0]   ret_pc_o,
  output logic [3:0]      dbg_reason_o
);
  // chain order: 0 status, 1 pc, 2 exception address, 3 type
  localparam logic [SELW-1:0] TOP_SEL  [NCHAIN] = '{S_SST, S_SPC, S_EVA, S_TYP};
  localparam logic [SELW-1:0] PREV_SEL [NCHAIN] = '{S_PSST, S_PSPC, S_PEVA, S_PTYP};

  logic [DW-1:0] status_q, ovpc_q, pg26_q, pg27_q, status_nxt;
  logic [DW-1:0] c_din [NCHAIN];
  logic [DW-1:0] c_top [NCHAIN];
  logic [DW-1:0] c_prev[NCHAIN];
  logic push, deep, pop, ovf, dbg_ok, wr;

  ils_ctrl #(.MAX_LEVEL(MAX_LEVEL)) u_ctrl (
    .irq(irq_i), .ret(ret_i), .status(status_q), .sst(c_top[0]),
    .push(push), .deep(deep), .pop(pop), .ovf(ovf), .dbg_ok(dbg_ok),
    .status_nxt(status_nxt)
  );

  assign wr = dbg_we_i && dbg_ok;
  assign c_din[0] = status_q;
  assign c_din[1] = pc_i;
  assign c_din[2] = irq_addr_i;
  assign c_din[3] = {{(DW-4){1'b0}}, irq_type_i};

  for (genvar i = 0; i < NCHAIN; i++) begin : g_chain
    ils_shadow #(.W(DW)) u_sh (
      .clk(clk), .rst_n(rst_n), .push(push), .deep(deep), .pop(pop),
      .din(c_din[i]),
      .wr_top(wr && (dbg_sel_i == TOP_SEL[i])),
      .wr_prev(wr && (dbg_sel_i == PREV_SEL[i])),
      .wdata(dbg_wdata_i), .top(c_top[i]), .prev(c_prev[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ovpc_q   <= '0;
      pg26_q   <= '0;
      pg27_q   <= '0;
    end else begin
      if (push || pop) status_q <= status_nxt;
      else if (wr && dbg_sel_i == S_STAT) status_q <= dbg_wdata_i;
      if (ovf) ovpc_q <= pc_i;
      else if (wr && dbg_sel_i == S_OVPC) ovpc_q <= dbg_wdata_i;
      if (push && deep) begin
        pg26_q <= gpr26_i;
        pg27_q <= gpr27_i;
      end else begin
        if (wr && dbg_sel_i == S_PG26) pg26_q <= dbg_wdata_i;
        if (wr && dbg_sel_i == S_PG27) pg27_q <= dbg_wdata_i;
      end
    end
  end

  always_comb begin
    case (dbg_sel_i)
      S_STAT:  dbg_rdata_o = status_q;
      S_SST:   dbg_rdata_o = c_top[0];
      S_PSST:  dbg_rdata_o = c_prev[0];
      S_SPC:   dbg_rdata_o = c_top[1];
      S_PSPC:  dbg_rdata_o = c_prev[1];
      S_OVPC:  dbg_rdata_o = ovpc_q;
      S_EVA:   dbg_rdata_o = c_top[2];
      S_PEVA:  dbg_rdata_o = c_prev[2];
      S_TYP:   dbg_rdata_o = c_top[3];
      S_PTYP:  dbg_rdata_o = c_prev[3];
      S_PG26:  dbg_rdata_o = pg26_q;
      S_PG27:  dbg_rdata_o = pg27_q;
      default: dbg_rdata_o = '0;
    endcase
  end

  assign status_o     = status_q;
  assign ret_pc_o     = c_top[1];
  assign dbg_reason_o = c_top[3][3:0];
endmodule

// File: rtl/ils_stacker_chk.sv
module ils_stacker_chk #(
  parameter int MAX_LEVEL = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_i,
  input logic        ret_i,
  input logic [31:0] pc_i,
  input logic [31:0] status_o,
  input logic [31:0] ret_pc_o
);
  localparam logic [1:0] MAXL = 2'(MAX_LEVEL);
  logic [1:0] lvl;
  assign lvl = status_o[2:1];

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= MAXL);
  a_r3_entry_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && lvl < MAXL) |=> (lvl == $past(lvl) + 2'd1) && !status_o[0] && !status_o[11]);
  a_r3_entry_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && lvl < MAXL) |=> ret_pc_o == $past(pc_i));
  a_r5_at_max_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && lvl == MAXL) |=> $stable(status_o) && $stable(ret_pc_o));
  a_r6_return_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !irq_i && lvl != 2'd0) |=> lvl == $past(lvl) - 2'd1);
  a_r7_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !irq_i && lvl == 2'd0) |=> $stable(status_o));
endmodule

bind ils_stacker ils_stacker_chk #(.MAX_LEVEL(MAX_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ret_i(ret_i), .pc_i(pc_i),
  .status_o(status_o), .ret_pc_o(ret_pc_o)
);

// File: tb/ils_stacker_test.sv
module ils_stacker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_i = 0, ret_i = 0, dbg_we_i = 0;
  logic [3:0] irq_type_i = 0, dbg_sel_i = 0;
  logic [31:0] irq_addr_i = 0, pc_i = 0, gpr26_i = 0, gpr27_i = 0, dbg_wdata_i = 0;
  logic [31:0] dbg_rdata_o, status_o, ret_pc_o;
  logic [3:0] dbg_reason_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ils_stacker #(.MAX_LEVEL(3)) uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .irq_type_i(irq_type_i),
    .irq_addr_i(irq_addr_i), .pc_i(pc_i), .gpr26_i(gpr26_i), .gpr27_i(gpr27_i),
    .ret_i(ret_i), .dbg_we_i(dbg_we_i), .dbg_sel_i(dbg_sel_i),
    .dbg_wdata_i(dbg_wdata_i), .dbg_rdata_o(dbg_rdata_o), .status_o(status_o),
    .ret_pc_o(ret_pc_o), .dbg_reason_o(dbg_reason_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; one rising edge then applies them
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    irq_i = 0; ret_i = 0; dbg_we_i = 0;
  endtask

  task automatic rd(input string req, input logic [3:0] sel, input logic [31:0] exp);
    dbg_sel_i = sel;
    #1;
    chk(req, dbg_rdata_o, exp);
  endtask

  task automatic dwr(input logic [3:0] sel, input logic [31:0] d);
    dbg_we_i = 1; dbg_sel_i = sel; dbg_wdata_i = d;
    step();
  endtask

  task automatic enter(input logic [31:0] pc, input logic [31:0] a, input logic [3:0] t);
    irq_i = 1; pc_i = pc; irq_addr_i = a; irq_type_i = t;
    step();
  endtask

  task automatic t_reset();
    for (int s = 0; s < 16; s++) rd("R1", 4'(s), 32'h0);
    chk("R1", status_o, 0);
    chk("R1", ret_pc_o, 0);
  endtask

  task automatic t_dbg_write();
    dwr(4'd0, 32'h8C1);
    rd("R9", 4'd0, 32'h8C1);
    dwr(4'd15, 32'hFFFF);
    rd("R9", 4'd15, 32'h0);
  endtask

  task automatic t_first_entry();
    enter(32'h100, 32'hA0, 4'd5);
    chk("R3", status_o, 32'h002);
    rd("R3", 4'd1, 32'h8C1);
    rd("R3", 4'd6, 32'hA0);
    rd("R3", 4'd8, 32'h5);
    chk("R8", {28'h0, dbg_reason_o}, 32'h5);
    chk("R12", ret_pc_o, 32'h100);
  endtask

  task automatic t_nested_entry();
    dwr(4'd0, 32'h803);
    gpr26_i = 32'h26; gpr27_i = 32'h27;
    enter(32'h200, 32'hB0, 4'd9);
    chk("R3", status_o, 32'h004);
    rd("R4", 4'd2, 32'h8C1);
    rd("R4", 4'd4, 32'h100);
    rd("R4", 4'd7, 32'hA0);
    rd("R4", 4'd9, 32'h5);
    rd("R4", 4'd10, 32'h26);
    rd("R4", 4'd11, 32'h27);
    chk("R12", ret_pc_o, 32'h200);
    dwr(4'd0, 32'h805);
    enter(32'h300, 32'hC0, 4'd3);
    chk("R2", status_o, 32'h006);
    rd("R11", 4'd2, 32'h803);
    rd("R3", 4'd1, 32'h805);
  endtask

  task automatic t_at_max();
    enter(32'h400, 32'hD0, 4'd7);
    rd("R5", 4'd5, 32'h400);
    chk("R5", status_o, 32'h006);
    rd("R5", 4'd1, 32'h805);
    chk("R5", ret_pc_o, 32'h300);
    chk("R5", {28'h0, dbg_reason_o}, 32'h3);
  endtask

  task automatic t_returns();
    ret_i = 1; step();
    chk("R6", status_o, 32'h805);
    rd("R6", 4'd1, 32'h803);
    chk("R6", ret_pc_o, 32'h200);
    chk("R8", {28'h0, dbg_reason_o}, 32'h9);
    // return collides with a debugger write to the live status
    ret_i = 1; dbg_we_i = 1; dbg_sel_i = 4'd0; dbg_wdata_i = 32'hFFFF;
    step();
    chk("R10", status_o, 32'h803);
    ret_i = 1; step();
    chk("R6", status_o, 32'h801);
    ret_i = 1; step();
    chk("R7", status_o, 32'h801);
    rd("R7", 4'd1, 32'h803);
  endtask

  task automatic t_collide();
    irq_i = 1; ret_i = 1; pc_i = 32'h500; irq_type_i = 4'd2;
    step();
    chk("R10", status_o, 32'h002);
    chk("R10", ret_pc_o, 32'h500);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_dbg_write();
    t_first_entry();
    t_nested_entry();
    t_at_max();
    t_returns();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule